// File: doc/BRIEF.md
# Narrow-to-Wide Memory Write Adapter

This block turns a write port of narrow granularity into an equivalent write port on a memory built from wide words. A wide word holds `2^K` base units. The narrow port already covers `2^P` base units, so one wide word carries `2^(K-P)` lanes, each the width of the narrow data. The adapter puts a copy of the narrow data on every lane. It clears the lane-select field of the address and gates each lane's per-bit enables with a decoder that compares the lane field of the narrow address to that lane's index. A build-time variant serves a port whose lane is fixed: only that lane carries enables and data, and the other lanes are zero.

A wrapper holds a behavioural wide-word array whose base offset and size are pushed out to wide-word boundaries. The base is rounded down, the size grows by the amount removed and is then rounded up. A combinational narrow-word lookup port lets the array's contents be compared with a plain narrow-word memory. Addresses are counted in base units throughout. The reset input is asynchronous, active low, and is released inside the block through a two-flop synchronizer.

Top module: `wadapt_top`

## Requirements
- R1: The wide write address equals the narrow address with bits [K-1:P] cleared; bits below P and bits from K upward are carried over unchanged.
- R2: In the default (address-decoded) mode every lane i of the wide data, bits [i*NW +: NW], equals the narrow data, with no shift or rotation.
- R3: In the default mode the enables of lane i equal the narrow enables when address bits [K-1:P] equal i, and are all zero otherwise; at most one lane carries any enable.
- R4: With FIXED_LANE set to a lane index L, only lane L carries the narrow enables and data, and every other lane has zero enables and zero data, whatever the address.
- R5: The array spans base addresses from START rounded down to a multiple of 2^K, over SIZE plus the amount removed, rounded up to a multiple of 2^K. With the defaults (START 5, SIZE 37, K 3) this is 0 to 47. Writes inside that span are stored, including below START, and writes at 48 or above change nothing.
- R6: A write takes effect on the rising clock edge and changes only bits whose wide enable is 1; other bits of the same lane, and all other lanes and words, keep their contents.
- R7: After reset every narrow word reads zero.
- R8: The lookup port returns the narrow word at base address A (lane (A>>P) mod 2^(K-P) of wide word A>>K, relative to the aligned base) combinationally, and returns zero outside the span; a write to the looked-up word shows the old value until the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nar_wr_addr | input | AW | Narrow write address in base units |
| nar_wr_data | input | NW | Narrow write data (BW<<P bits) |
| nar_wr_en | input | NW | Narrow per-bit write enables |
| wide_wr_addr | output | AW | Lane-aligned wide write address |
| wide_wr_data | output | WW | Replicated wide data (BW<<K bits) |
| wide_wr_en | output | WW | Lane-gated per-bit wide enables |
| peek_addr | input | AW | Lookup address in base units |
| peek_data | output | NW | Narrow word at the lookup address |

## Verification
A write and a lookup of the same narrow word can fall in the same cycle. The bench sets the lookup address to the address being written. Before the edge it expects the old contents from its own narrow-word model, and after the edge it expects the merged value, so a write that leaks through combinationally or lands a cycle late is caught. After each write the bench also sweeps every narrow address. This catches lane, word-offset or enable-masking errors that spill into neighbouring words, and covers addresses below the unaligned start and beyond the rounded-up end.

// File: rtl/wadapt_pkg.sv
package wadapt_pkg;

  // Base of the array after rounding down to a wide-word boundary.
  function automatic int align_base(input int base, input int k);
    int m;
    m = (1 << k) - 1;
    return base & ~m;
  endfunction

  // Span after absorbing the base remainder and rounding up to a wide word.
  function automatic int align_span(input int base, input int span, input int k);
    int m;
    int s;
    m = (1 << k) - 1;
    s = span + (base & m);
    if ((s & m) != 0) s = (s | m) + 1;
    return s;
  endfunction

endpackage

// File: rtl/wadapt_lane.sv
module wadapt_lane #(
  parameter int NW        = 8,
  parameter bit CARRY_DAT = 1'b1
) (
  input  logic          sel,
  input  logic [NW-1:0] din,
  input  logic [NW-1:0] ein,
  output logic [NW-1:0] dout,
  output logic [NW-1:0] eout
);

  always_comb begin
    eout = sel ? ein : '0;
  end

  generate
    if (CARRY_DAT) begin : g_dat
      assign dout = din;
    end else begin : g_zero
      assign dout = '0;
    end
  endgenerate

endmodule

// File: rtl/wadapt_adapter.sv
module wadapt_adapter #(
  parameter int AW         = 6,
  parameter int BW         = 4,
  parameter int P          = 1,
  parameter int K          = 3,
  parameter int FIXED_LANE = -1,
  localparam int NW        = BW << P,
  localparam int WW        = BW << K,
  localparam int LANES     = 1 << (K - P)
) (
  input  logic [AW-1:0] nar_addr,
  input  logic [NW-1:0] nar_data,
  input  logic [NW-1:0] nar_en,
  output logic [AW-1:0] wide_addr,
  output logic [WW-1:0] wide_data,
  output logic [WW-1:0] wide_en
);

  localparam logic [AW-1:0] KMASK    = AW'((1 << K) - 1);
  localparam logic [AW-1:0] LANEMASK = AW'(((1 << K) - 1) & ~((1 << P) - 1));

  generate
    if (LANES == 1) begin : g_pass
      assign wide_addr = nar_addr;
      assign wide_data = nar_data;
      assign wide_en   = nar_en;
    end else begin : g_widen
      logic [AW-1:0] lane_idx;

      always_comb begin
        lane_idx  = (nar_addr & KMASK) >> P;
        wide_addr = nar_addr & ~LANEMASK;
      end

      for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic sel;
        if (FIXED_LANE < 0) begin : g_dec
          assign sel = (lane_idx == AW'(l));
        end else begin : g_fix
          assign sel = (FIXED_LANE == l);
        end

        wadapt_lane #(
          .NW       (NW),
          .CARRY_DAT((FIXED_LANE < 0) || (FIXED_LANE == l))
        ) u_lane (
          .sel (sel),
          .din (nar_data),
          .ein (nar_en),
          .dout(wide_data[l*NW +: NW]),
          .eout(wide_en[l*NW +: NW])
        );
      end
    end
  endgenerate

endmodule

// File: rtl/wadapt_mem.sv
module wadapt_mem #(
  parameter int AW    = 6,
  parameter int BW    = 4,
  parameter int P     = 1,
  parameter int K     = 3,
  parameter int START = 5,
  parameter int SIZE  = 37,
  localparam int NW   = BW << P,
  localparam int WW   = BW << K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic [WW-1:0] wr_en,
  input  logic [AW-1:0] pk_addr,
  output logic [NW-1:0] pk_data
);

  localparam int ABASE = wadapt_pkg::align_base(START, K);
  localparam int ASPAN = wadapt_pkg::align_span(START, SIZE, K);
  localparam int DEPTH = ASPAN >> K;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW+1:0] BASE_X = (AW+2)'(ABASE);
  localparam logic [AW+1:0] SPAN_X = (AW+2)'(ASPAN);
  localparam logic [AW-1:0] KMASK  = AW'((1 << K) - 1);

  logic [WW-1:0] mem_q [DEPTH];
  logic [WW-1:0] mem_d [DEPTH];

  logic [AW+1:0] wr_off;
  logic          wr_hit;
  logic [IW-1:0] wr_idx;

  logic [AW+1:0] pk_off;
  logic          pk_hit;
  logic [IW-1:0] pk_idx;
  logic [AW-1:0] pk_lane;
  logic [WW-1:0] pk_word;

  // Write side: offset from aligned base; a wrap below base lands out of span.
  always_comb begin
    wr_off = {2'b00, wr_addr} - BASE_X;
    wr_hit = (wr_off < SPAN_X) && (wr_en != '0);
    wr_idx = IW'(wr_off >> K);
  end

  // Next-state: bitwise merge into the addressed wide word.
  always_comb begin
    mem_d = mem_q;
    if (wr_hit) begin
      mem_d[wr_idx] = (mem_q[wr_idx] & ~wr_en) | (wr_data & wr_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_hit) begin
      mem_q <= mem_d;
    end
  end

  // Lookup side.
  always_comb begin
    pk_off  = {2'b00, pk_addr} - BASE_X;
    pk_hit  = (pk_off < SPAN_X);
    pk_idx  = IW'(pk_off >> K);
    pk_lane = (pk_addr & KMASK) >> P;
    pk_word = mem_q[pk_idx];
    pk_data = pk_hit ? NW'(pk_word >> (NW * int'(pk_lane))) : '0;
  end

endmodule

// File: rtl/wadapt_top.sv
module wadapt_top #(
  parameter int AW         = 6,
  parameter int BW         = 4,
  parameter int P          = 1,
  parameter int K          = 3,
  parameter int START      = 5,
  parameter int SIZE       = 37,
  parameter int FIXED_LANE = -1,
  localparam int NW        = BW << P,
  localparam int WW        = BW << K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] nar_wr_addr,
  input  logic [NW-1:0] nar_wr_data,
  input  logic [NW-1:0] nar_wr_en,
  output logic [AW-1:0] wide_wr_addr,
  output logic [WW-1:0] wide_wr_data,
  output logic [WW-1:0] wide_wr_en,
  input  logic [AW-1:0] peek_addr,
  output logic [NW-1:0] peek_data
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  wadapt_adapter #(
    .AW(AW), .BW(BW), .P(P), .K(K), .FIXED_LANE(FIXED_LANE)
  ) u_adapter (
    .nar_addr (nar_wr_addr),
    .nar_data (nar_wr_data),
    .nar_en   (nar_wr_en),
    .wide_addr(wide_wr_addr),
    .wide_data(wide_wr_data),
    .wide_en  (wide_wr_en)
  );

  wadapt_mem #(
    .AW(AW), .BW(BW), .P(P), .K(K), .START(START), .SIZE(SIZE)
  ) u_mem (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_addr(wide_wr_addr),
    .wr_data(wide_wr_data),
    .wr_en  (wide_wr_en),
    .pk_addr(peek_addr),
    .pk_data(peek_data)
  );

endmodule

// File: rtl/wadapt_chk.sv
module wadapt_chk #(
  parameter int AW         = 6,
  parameter int NW         = 8,
  parameter int WW         = 32,
  parameter int P          = 1,
  parameter int K          = 3,
  parameter int FIXED_LANE = -1,
  localparam int LANES     = 1 << (K - P)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] nar_wr_addr,
  input logic [NW-1:0] nar_wr_data,
  input logic [NW-1:0] nar_wr_en,
  input logic [AW-1:0] wide_wr_addr,
  input logic [WW-1:0] wide_wr_data,
  input logic [WW-1:0] wide_wr_en,
  input logic [AW-1:0] peek_addr,
  input logic [NW-1:0] peek_data
);

  localparam logic [AW-1:0] KMASK = AW'((1 << K) - 1);

  logic [LANES-1:0] lane_act;
  logic [AW-1:0]    sel_lane;

  always_comb begin
    sel_lane = (FIXED_LANE < 0) ? ((nar_wr_addr & KMASK) >> P) : AW'(FIXED_LANE);
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_act
      assign lane_act[l] = |wide_wr_en[l*NW +: NW];
      if (FIXED_LANE < 0) begin : g_rep
        assert_lane_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
          wide_wr_data[l*NW +: NW] == nar_wr_data);
      end else if (FIXED_LANE != l) begin : g_quiet
        assert_idle_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
          (wide_wr_data[l*NW +: NW] == '0) && (wide_wr_en[l*NW +: NW] == '0));
      end
    end
  endgenerate

  // R1: upper and lower address fields survive alignment.
  assert_addr_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((wide_wr_addr >> K) == (nar_wr_addr >> K)) &&
    ((wide_wr_addr & AW'((1 << P) - 1)) == (nar_wr_addr & AW'((1 << P) - 1))));

  // R3: never more than one lane enabled.
  assert_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_act));

  // R3: selected lane carries exactly the narrow enables.
  assert_sel_lane_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    NW'(wide_wr_en >> (NW * int'(sel_lane))) == nar_wr_en);

  // R8: no enable and an unchanged lookup address keep the lookup data still.
  assert_peek_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_wr_en == '0) |=> (!$stable(peek_addr) || $stable(peek_data)));

endmodule

bind wadapt_top wadapt_chk #(
  .AW(AW), .NW(NW), .WW(WW), .P(P), .K(K), .FIXED_LANE(FIXED_LANE)
) u_wadapt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nar_wr_addr (nar_wr_addr),
  .nar_wr_data (nar_wr_data),
  .nar_wr_en   (nar_wr_en),
  .wide_wr_addr(wide_wr_addr),
  .wide_wr_data(wide_wr_data),
  .wide_wr_en  (wide_wr_en),
  .peek_addr   (peek_addr),
  .peek_data   (peek_data)
);

// File: tb/wadapt_top_bench.sv
module wadapt_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int BW = 4;
  localparam int P  = 1;
  localparam int K  = 3;
  localparam int NW = BW << P;
  localparam int WW = BW << K;
  localparam int LANES = 1 << (K - P);
  localparam int SPAN_END = 48;
  localparam int FIX_L = 2;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] nar_wr_addr;
  logic [NW-1:0] nar_wr_data;
  logic [NW-1:0] nar_wr_en;
  logic [AW-1:0] wide_wr_addr;
  logic [WW-1:0] wide_wr_data;
  logic [WW-1:0] wide_wr_en;
  logic [AW-1:0] peek_addr;
  logic [NW-1:0] peek_data;

  logic [AW-1:0] fx_addr;
  logic [WW-1:0] fx_data;
  logic [WW-1:0] fx_en;
  logic [NW-1:0] fx_peek;

  int n_cmp;
  int n_bad;
  bit finished;

  logic [NW-1:0] ref_mem [1 << (AW - P)];

  wadapt_top u_wadapt_top (
    .clk(clk), .rst_n(rst_n),
    .nar_wr_addr(nar_wr_addr), .nar_wr_data(nar_wr_data), .nar_wr_en(nar_wr_en),
    .wide_wr_addr(wide_wr_addr), .wide_wr_data(wide_wr_data), .wide_wr_en(wide_wr_en),
    .peek_addr(peek_addr), .peek_data(peek_data)
  );

  wadapt_top #(.FIXED_LANE(FIX_L)) u_wadapt_top_fix (
    .clk(clk), .rst_n(rst_n),
    .nar_wr_addr(nar_wr_addr), .nar_wr_data(nar_wr_data), .nar_wr_en(nar_wr_en),
    .wide_wr_addr(fx_addr), .wide_wr_data(fx_data), .wide_wr_en(fx_en),
    .peek_addr('0), .peek_data(fx_peek)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, nar_wr_addr, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic sweep(input string req);
    for (int j = 0; j < (1 << AW); j += (1 << P)) begin
      peek_addr = AW'(j);
      #1;
      check(req, 64'(peek_data), 64'(ref_mem[j >> P]));
    end
  endtask

  task automatic do_write(input int a, input logic [NW-1:0] d, input logic [NW-1:0] e);
    logic [AW-1:0] exp_addr;
    logic [WW-1:0] exp_data;
    logic [WW-1:0] exp_en;
    logic [WW-1:0] fx_exp_data;
    logic [WW-1:0] fx_exp_en;
    int lane;
    @(negedge clk);
    nar_wr_addr = AW'(a);
    nar_wr_data = d;
    nar_wr_en   = e;
    peek_addr   = AW'(a);
    #1;
    lane = (a % (1 << K)) / (1 << P);
    exp_addr = AW'(a - lane * (1 << P));
    exp_data = '0; exp_en = '0; fx_exp_data = '0; fx_exp_en = '0;
    for (int l = 0; l < LANES; l++) begin
      exp_data[l*NW +: NW] = d;
      if (l == lane) exp_en[l*NW +: NW] = e;
    end
    fx_exp_data[FIX_L*NW +: NW] = d;
    fx_exp_en[FIX_L*NW +: NW]   = e;
    check("R1", 64'(wide_wr_addr), 64'(exp_addr));
    check("R2", 64'(wide_wr_data), 64'(exp_data));
    check("R3", 64'(wide_wr_en), 64'(exp_en));
    check("R4 data", 64'(fx_data), 64'(fx_exp_data));
    check("R4 en", 64'(fx_en), 64'(fx_exp_en));
    check("R8 old before edge", 64'(peek_data), 64'(ref_mem[a >> P]));
    @(posedge clk);
    if (a < SPAN_END) ref_mem[a >> P] = (ref_mem[a >> P] & ~e) | (d & e);
    @(negedge clk);
    nar_wr_en = '0;
    #1;
    check("R8 new after edge", 64'(peek_data), 64'(ref_mem[a >> P]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    finished = 1'b0;
    for (int i = 0; i < (1 << (AW - P)); i++) ref_mem[i] = '0;
    rst_n = 1'b0;
    nar_wr_addr = '0;
    nar_wr_data = '0;
    nar_wr_en   = '0;
    peek_addr   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: cleared contents after reset.
    sweep("R7");

    // R5/R6: every address, including below the unaligned start and past the end.
    for (int a = 0; a < (1 << AW); a++) begin
      logic [NW-1:0] d;
      d = NW'(8'h3c ^ (a * 37));
      do_write(a, d, 8'hff);
      sweep(a < SPAN_END ? "R5 R6 full write" : "R5 beyond span ignored");
    end
    // R6: partial enables merge only chosen bits.
    for (int a = 0; a < (1 << AW); a += 3) begin
      do_write(a, 8'h5a ^ NW'(a), 8'h0f);
      do_write(a, 8'hc3, 8'ha4);
      do_write(a, 8'hff, 8'h00);
      sweep("R6 partial merge");
    end
    finish_run();
  end

endmodule